// File: doc/BRIEF.md
# Compact branch condition resolver

This block decides the outcome of the branch and jump forms that share major-opcode groups in a 64-bit pipeline. These are the newer compact forms, which have no delay slot, and the older forms of the same opcodes, which execute one delay-slot instruction. The front end supplies a decoded group code, the two source register numbers, their 64-bit values, the raw 26-bit immediate field, the PC of the branch and a bit that selects the newer architecture variant. One cycle later the block returns four results: whether the branch is taken, the PC to fetch next, whether register 31 must be written (and with what), and whether a delay slot follows.

Within a single group, comparisons between the register numbers select the branch kind. Equal numbers, a zero rs number, or rs number at least rt number each pick a different condition. The same opcode can also fall back to a legacy delay-slot branch, or to a non-branch, when the variant bit is clear.

Top module: `cbr_resolver`

## Requirements
- R1: Results are registered. `out_valid` is high exactly one cycle after `in_valid` is high. Synchronous active-high reset clears `out_valid`, `taken`, `link_en` and `delay_slot`.
- R2: Group code 0 with `variant_new`=1 and rt number non-zero selects a compact form with a 16-bit offset (imm[15:0]). If the rs number is 0, the branch is taken with link when signed rt <= 0. If the rs number equals the rt number, it is taken with link when signed rt >= 0. Otherwise it is taken without link when rs >= rt, compared unsigned.
- R3: Group code 0 with `variant_new`=0 or rt number 0 is a delay-slot branch with no link. It is taken when signed rs <= 0 and goes to PC+4+(sext(imm[15:0])<<2). When not taken, the next PC is PC+8. `delay_slot` is 1.
- R4: Group code 1 with `variant_new`=1 is resolved in three steps. If the rs number is at least the rt number, the branch is taken (no link) when the signed 64-bit sum rs+rt overflows. Otherwise, if the rs number is 0, it is taken with link when rt == 0. Otherwise, it is taken when rs == rt. All three use a 16-bit offset.
- R5: Group code 2 with `variant_new`=1 uses the same selection as group 1 with inverted conditions: no overflow of rs+rt, rt != 0 (with link), and rs != rt. The no-overflow case is therefore always taken when either operand is zero or the signs differ.
- R6: Group codes 1 and 2 with `variant_new`=0 are not branches: not taken, next PC is PC+4, no link, no delay slot.
- R7: For group code 3 with a non-zero rs number, the branch is taken when rs == 0, using a 21-bit offset (imm[20:0]). With rs number 0, it is an always-taken jump to rt+sext(imm[15:0]) with no link.
- R8: For group code 4 with a non-zero rs number, the branch is taken when rs != 0, using a 21-bit offset. With rs number 0, it is an always-taken jump to rt+sext(imm[15:0]) that links.
- R9: Group code 5 is always taken to PC+4+(sext(imm[25:0])<<2) without link. Group code 6 is the same with link.
- R10: Every compact form has `delay_slot`=0. A taken compact branch goes to PC+4 plus the sign-extended offset shifted left by two. A not-taken compact branch goes to PC+4. `link_en` is high only when the branch is taken, and `link_val` is then PC+4.
- R11: Group code 7 is never taken: next PC is PC+4, no link, no delay slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Branch to resolve this cycle |
| grp | input | 3 | Opcode group code (see requirements) |
| rs_num | input | RNUM_W | rs register number |
| rt_num | input | RNUM_W | rt register number |
| rs_val | input | XLEN | rs register value |
| rt_val | input | XLEN | rt register value |
| imm | input | IMM_W | Raw immediate field |
| pc | input | XLEN | PC of the branch |
| variant_new | input | 1 | 1 selects the compact-branch variant |
| out_valid | output | 1 | Result valid |
| taken | output | 1 | Branch or jump taken |
| next_pc | output | XLEN | Next fetch PC |
| link_en | output | 1 | Write link value to register 31 |
| link_val | output | XLEN | Return address to write |
| delay_slot | output | 1 | A delay-slot instruction follows |

## Verification
Two functions meet in one cycle in the overflow groups. The register-number comparison that selects the branch kind and the 64-bit overflow test on the register values both act on the same instruction. Vectors set the rs number equal to, above and below the rt number while the values sit at the signed limits (maximum plus one, minimum plus minus one, zero operands, opposite signs). The reference model judges the selected condition and the resulting link and next PC together. A second meeting point is `link_en` with `taken`: linking forms are driven both taken and not taken, and the link value is checked only when the link is expected.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

    typedef enum logic [2:0] {
        GRP_LINKCMP = 3'd0,
        GRP_ADDOVF  = 3'd1,
        GRP_ADDNOVF = 3'd2,
        GRP_ZEROJ   = 3'd3,
        GRP_NZEROJL = 3'd4,
        GRP_ALWAYS  = 3'd5,
        GRP_ALWAYSL = 3'd6,
        GRP_NONE    = 3'd7
    } grp_e;

    typedef enum logic [3:0] {
        C_NEVER, C_ALWAYS, C_RT_LEZ, C_RT_GEZ, C_GEU, C_RS_LEZ,
        C_OVF, C_NOVF, C_RT_EQZ, C_RT_NEZ, C_EQ, C_NE, C_RS_EQZ, C_RS_NEZ
    } cond_e;

    typedef enum logic [1:0] {
        TGT_OFF_S, TGT_OFF_M, TGT_OFF_L, TGT_REG
    } tgt_e;

    typedef struct packed {
        cond_e cond;
        tgt_e  tgt;
        logic  link;
        logic  slot;
    } kind_t;

    localparam int OFF_S_W = 16;
    localparam int OFF_M_W = 21;

    function automatic kind_t mk_kind(cond_e c, tgt_e t, logic l, logic s);
        kind_t k;
        k.cond = c;
        k.tgt  = t;
        k.link = l;
        k.slot = s;
        return k;
    endfunction

endpackage

// File: rtl/cbr_decode.sv
module cbr_decode
    import cbr_pkg::*;
#(
    parameter int RNUM_W = 5
) (
    input  logic [2:0]        grp,
    input  logic [RNUM_W-1:0] rs_num,
    input  logic [RNUM_W-1:0] rt_num,
    input  logic              variant_new,
    output kind_t             kind
);

    logic rs_zero, rt_zero, nums_eq, rs_ge_rt;

    always_comb begin
        rs_zero  = (rs_num == '0);
        rt_zero  = (rt_num == '0);
        nums_eq  = (rs_num == rt_num);
        rs_ge_rt = (rs_num >= rt_num);
    end

    always_comb begin
        kind = mk_kind(C_NEVER, TGT_OFF_S, 1'b0, 1'b0);
        case (grp_e'(grp))
            GRP_LINKCMP: begin
                if (variant_new && !rt_zero) begin
                    if (rs_zero)      kind = mk_kind(C_RT_LEZ, TGT_OFF_S, 1'b1, 1'b0);
                    else if (nums_eq) kind = mk_kind(C_RT_GEZ, TGT_OFF_S, 1'b1, 1'b0);
                    else              kind = mk_kind(C_GEU,    TGT_OFF_S, 1'b0, 1'b0);
                end else begin
                    kind = mk_kind(C_RS_LEZ, TGT_OFF_S, 1'b0, 1'b1);
                end
            end
            GRP_ADDOVF: begin
                if (variant_new) begin
                    if (rs_ge_rt)     kind = mk_kind(C_OVF,    TGT_OFF_S, 1'b0, 1'b0);
                    else if (rs_zero) kind = mk_kind(C_RT_EQZ, TGT_OFF_S, 1'b1, 1'b0);
                    else              kind = mk_kind(C_EQ,     TGT_OFF_S, 1'b0, 1'b0);
                end
            end
            GRP_ADDNOVF: begin
                if (variant_new) begin
                    if (rs_ge_rt)     kind = mk_kind(C_NOVF,   TGT_OFF_S, 1'b0, 1'b0);
                    else if (rs_zero) kind = mk_kind(C_RT_NEZ, TGT_OFF_S, 1'b1, 1'b0);
                    else              kind = mk_kind(C_NE,     TGT_OFF_S, 1'b0, 1'b0);
                end
            end
            GRP_ZEROJ: begin
                if (!rs_zero) kind = mk_kind(C_RS_EQZ, TGT_OFF_M, 1'b0, 1'b0);
                else          kind = mk_kind(C_ALWAYS, TGT_REG,   1'b0, 1'b0);
            end
            GRP_NZEROJL: begin
                if (!rs_zero) kind = mk_kind(C_RS_NEZ, TGT_OFF_M, 1'b0, 1'b0);
                else          kind = mk_kind(C_ALWAYS, TGT_REG,   1'b1, 1'b0);
            end
            GRP_ALWAYS:  kind = mk_kind(C_ALWAYS, TGT_OFF_L, 1'b0, 1'b0);
            GRP_ALWAYSL: kind = mk_kind(C_ALWAYS, TGT_OFF_L, 1'b1, 1'b0);
            default:     kind = mk_kind(C_NEVER,  TGT_OFF_S, 1'b0, 1'b0);
        endcase
    end

endmodule

// File: rtl/cbr_cond.sv
module cbr_cond
    import cbr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  cond_e           cond,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    output logic            hit
);

    logic [XLEN-1:0] sum;
    logic            ovf;

    always_comb begin
        sum = rs_val + rt_val;
        ovf = (rs_val[XLEN-1] == rt_val[XLEN-1]) && (sum[XLEN-1] != rs_val[XLEN-1]);
    end

    always_comb begin
        case (cond)
            C_ALWAYS: hit = 1'b1;
            C_RT_LEZ: hit = rt_val[XLEN-1] || (rt_val == '0);
            C_RT_GEZ: hit = !rt_val[XLEN-1];
            C_GEU:    hit = (rs_val >= rt_val);
            C_RS_LEZ: hit = rs_val[XLEN-1] || (rs_val == '0);
            C_OVF:    hit = ovf;
            C_NOVF:   hit = !ovf;
            C_RT_EQZ: hit = (rt_val == '0);
            C_RT_NEZ: hit = (rt_val != '0);
            C_EQ:     hit = (rs_val == rt_val);
            C_NE:     hit = (rs_val != rt_val);
            C_RS_EQZ: hit = (rs_val == '0);
            C_RS_NEZ: hit = (rs_val != '0);
            default:  hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/cbr_target.sv
module cbr_target
    import cbr_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IMM_W = 26
) (
    input  tgt_e             tgt,
    input  logic [XLEN-1:0]  pc,
    input  logic [XLEN-1:0]  rt_val,
    input  logic [IMM_W-1:0] imm,
    output logic [XLEN-1:0]  tgt_pc,
    output logic [XLEN-1:0]  seq_pc,
    output logic [XLEN-1:0]  slot_pc
);

    localparam int ROOM_S = XLEN - OFF_S_W;
    localparam int ROOM_M = XLEN - OFF_M_W;
    localparam int ROOM_L = XLEN - IMM_W;

    logic [XLEN-1:0] off_s, off_m, off_l, off_sel;

    always_comb begin
        off_s   = {{ROOM_S{imm[OFF_S_W-1]}}, imm[OFF_S_W-1:0]};
        off_m   = {{ROOM_M{imm[OFF_M_W-1]}}, imm[OFF_M_W-1:0]};
        off_l   = {{ROOM_L{imm[IMM_W-1]}},   imm};
        seq_pc  = pc + XLEN'(4);
        slot_pc = pc + XLEN'(8);
        case (tgt)
            TGT_OFF_M: off_sel = off_m;
            TGT_OFF_L: off_sel = off_l;
            default:   off_sel = off_s;
        endcase
        if (tgt == TGT_REG) tgt_pc = rt_val + off_s;
        else                tgt_pc = seq_pc + (off_sel << 2);
    end

endmodule

// File: rtl/cbr_resolver.sv
module cbr_resolver
    import cbr_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int RNUM_W = 5,
    parameter int IMM_W  = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        grp,
    input  logic [RNUM_W-1:0] rs_num,
    input  logic [RNUM_W-1:0] rt_num,
    input  logic [XLEN-1:0]   rs_val,
    input  logic [XLEN-1:0]   rt_val,
    input  logic [IMM_W-1:0]  imm,
    input  logic [XLEN-1:0]   pc,
    input  logic              variant_new,
    output logic              out_valid,
    output logic              taken,
    output logic [XLEN-1:0]   next_pc,
    output logic              link_en,
    output logic [XLEN-1:0]   link_val,
    output logic              delay_slot
);

    kind_t           kind;
    logic            hit;
    logic [XLEN-1:0] tgt_pc, seq_pc, slot_pc;
    logic [XLEN-1:0] nxt_d, lnk_d;

    cbr_decode #(.RNUM_W(RNUM_W)) u_dec (
        .grp(grp), .rs_num(rs_num), .rt_num(rt_num),
        .variant_new(variant_new), .kind(kind)
    );

    cbr_cond #(.XLEN(XLEN)) u_cond (
        .cond(kind.cond), .rs_val(rs_val), .rt_val(rt_val), .hit(hit)
    );

    cbr_target #(.XLEN(XLEN), .IMM_W(IMM_W)) u_tgt (
        .tgt(kind.tgt), .pc(pc), .rt_val(rt_val), .imm(imm),
        .tgt_pc(tgt_pc), .seq_pc(seq_pc), .slot_pc(slot_pc)
    );

    always_comb begin
        lnk_d = kind.slot ? slot_pc : seq_pc;
        if (hit)            nxt_d = tgt_pc;
        else if (kind.slot) nxt_d = slot_pc;
        else                nxt_d = seq_pc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            taken      <= 1'b0;
            next_pc    <= '0;
            link_en    <= 1'b0;
            link_val   <= '0;
            delay_slot <= 1'b0;
        end else begin
            out_valid  <= in_valid;
            taken      <= in_valid && hit;
            next_pc    <= nxt_d;
            link_en    <= in_valid && hit && kind.link;
            link_val   <= lnk_d;
            delay_slot <= in_valid && kind.slot;
        end
    end

endmodule

// File: rtl/cbr_checker.sv
module cbr_checker #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [2:0]      grp,
    input logic [XLEN-1:0] pc,
    input logic            out_valid,
    input logic            taken,
    input logic [XLEN-1:0] next_pc,
    input logic            link_en,
    input logic [XLEN-1:0] link_val,
    input logic            delay_slot
);

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r1_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r10_link_needs_taken: assert property (@(posedge clk) disable iff (rst)
        (out_valid && link_en) |-> taken);

    a_r10_link_value: assert property (@(posedge clk) disable iff (rst)
        (out_valid && link_en) |-> (link_val == $past(pc) + XLEN'(4)));

    a_r10_compact_no_slot: assert property (@(posedge clk) disable iff (rst)
        (in_valid && grp != 3'd0) |=> !delay_slot);

    a_r3_slot_fallthrough: assert property (@(posedge clk) disable iff (rst)
        (out_valid && delay_slot && !taken) |-> (next_pc == $past(pc) + XLEN'(8)));

    a_r9_always_taken: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (grp == 3'd5 || grp == 3'd6)) |=> taken);

    a_r11_never_taken: assert property (@(posedge clk) disable iff (rst)
        (in_valid && grp == 3'd7) |=> (!taken && next_pc == $past(pc) + XLEN'(4)));

endmodule

bind cbr_resolver cbr_checker #(.XLEN(XLEN)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .grp(grp), .pc(pc),
    .out_valid(out_valid), .taken(taken), .next_pc(next_pc),
    .link_en(link_en), .link_val(link_val), .delay_slot(delay_slot)
);

// File: tb/cbr_resolver_tb.sv
`timescale 1ns/100ps
module cbr_resolver_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  grp = '0;
    logic [4:0]  rs_num = '0, rt_num = '0;
    logic [63:0] rs_val = '0, rt_val = '0, pc = '0;
    logic [25:0] imm = '0;
    logic        variant_new = 1'b0;
    logic        out_valid, taken, link_en, delay_slot;
    logic [63:0] next_pc, link_val;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    cbr_resolver dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .grp(grp),
        .rs_num(rs_num), .rt_num(rt_num), .rs_val(rs_val), .rt_val(rt_val),
        .imm(imm), .pc(pc), .variant_new(variant_new),
        .out_valid(out_valid), .taken(taken), .next_pc(next_pc),
        .link_en(link_en), .link_val(link_val), .delay_slot(delay_slot)
    );

    // Behavioural reference model
    function automatic void model(
        input  logic [2:0] g, input logic [4:0] rsn, input logic [4:0] rtn,
        input  logic [63:0] a, input logic [63:0] b, input logic [25:0] im,
        input  logic [63:0] p, input bit vb,
        output bit tk, output logic [63:0] np, output bit le,
        output logic [63:0] lv, output bit ds, output string tag);
        longint o16, o21, o26;
        logic [64:0] s65;
        bit ovf;
        o16 = longint'(shortint'(im[15:0]));
        o21 = longint'(im[20:0]); if (im[20]) o21 = o21 - (longint'(1) << 21);
        o26 = longint'(im);       if (im[25]) o26 = o26 - (longint'(1) << 26);
        s65 = {a[63], a} + {b[63], b};
        ovf = (s65[64] != s65[63]);
        tk = 0; le = 0; ds = 0; lv = p + 64'd4; np = p + 64'd4; tag = "R11";
        case (g)
            3'd0: begin
                if (vb && rtn != 0) begin
                    tag = "R2";
                    if (rsn == 0)        begin tk = ($signed(b) <= 0); le = tk; end
                    else if (rsn == rtn) begin tk = ($signed(b) >= 0); le = tk; end
                    else                 tk = (a >= b);
                    if (tk) np = p + 64'd4 + 64'(o16 * 4);
                end else begin
                    tag = "R3"; ds = 1; tk = ($signed(a) <= 0);
                    np = tk ? p + 64'd4 + 64'(o16 * 4) : p + 64'd8;
                end
            end
            3'd1, 3'd2: begin
                if (!vb) tag = "R6";
                else begin
                    tag = (g == 3'd1) ? "R4" : "R5";
                    if (rsn >= rtn)    tk = (g == 3'd1) ? ovf : !ovf;
                    else if (rsn == 0) begin tk = (g == 3'd1) ? (b == 0) : (b != 0); le = tk; end
                    else               tk = (g == 3'd1) ? (a == b) : (a != b);
                    if (tk) np = p + 64'd4 + 64'(o16 * 4);
                end
            end
            3'd3, 3'd4: begin
                tag = (g == 3'd3) ? "R7" : "R8";
                if (rsn != 0) begin
                    tk = (g == 3'd3) ? (a == 0) : (a != 0);
                    if (tk) np = p + 64'd4 + 64'(o21 * 4);
                end else begin
                    tk = 1; np = b + 64'(o16); le = (g == 3'd4);
                end
            end
            3'd5, 3'd6: begin
                tag = "R9"; tk = 1; le = (g == 3'd6);
                np = p + 64'd4 + 64'(o26 * 4);
            end
            default: ;
        endcase
    endfunction

    bit          t_tk, t_le, t_ds;
    logic [63:0] t_np, t_lv;
    string       t_tag;
    bit          e_v, e_tk, e_le, e_ds;
    logic [63:0] e_np, e_lv;
    string       e_tag;

    always @(posedge clk) begin
        if (rst) e_v <= 0;
        else begin
            e_v <= in_valid;
            if (in_valid) begin
                model(grp, rs_num, rt_num, rs_val, rt_val, imm, pc, variant_new,
                      t_tk, t_np, t_le, t_lv, t_ds, t_tag);
                e_tk <= t_tk; e_np <= t_np; e_le <= t_le;
                e_lv <= t_lv; e_ds <= t_ds; e_tag <= t_tag;
            end
        end
    end

    // Compare on every cycle after reset (R1 valid timing, R10 compact rules)
    always @(negedge clk) begin
        if (!rst && !done) begin
            n_cmp++;
            if (out_valid !== e_v) begin
                n_bad++;
                $display("FAIL R1 out_valid act=%0b exp=%0b", out_valid, e_v);
            end else if (e_v) begin
                if (taken !== e_tk || next_pc !== e_np || link_en !== e_le ||
                    delay_slot !== e_ds || (e_le && link_val !== e_lv)) begin
                    n_bad++;
                    $display("FAIL %s act tk=%0b np=%h le=%0b lv=%h ds=%0b exp tk=%0b np=%h le=%0b lv=%h ds=%0b",
                             e_tag, taken, next_pc, link_en, link_val, delay_slot,
                             e_tk, e_np, e_le, e_lv, e_ds);
                end
            end
        end
    end

    task automatic drive(input logic [2:0] g, input logic [4:0] rsn, input logic [4:0] rtn,
                         input logic [63:0] a, input logic [63:0] b,
                         input logic [25:0] im, input logic [63:0] p, input bit vb);
        @(negedge clk);
        in_valid = 1; grp = g; rs_num = rsn; rt_num = rtn; rs_val = a; rt_val = b;
        imm = im; pc = p; variant_new = vb;
    endtask

    function automatic logic [63:0] pick_val();
        case ($urandom_range(0, 6))
            0: return 64'd0;
            1: return 64'd1;
            2: return '1;
            3: return 64'h7fff_ffff_ffff_ffff;
            4: return 64'h8000_0000_0000_0000;
            default: return {$urandom(), $urandom()};
        endcase
    endfunction

    localparam logic [63:0] MAXP = 64'h7fff_ffff_ffff_ffff;
    localparam logic [63:0] MINN = 64'h8000_0000_0000_0000;
    localparam logic [63:0] PC0  = 64'h0000_0000_0040_1000;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_cmp++;
        if (out_valid !== 0 || taken !== 0 || link_en !== 0 || delay_slot !== 0) begin
            n_bad++;
            $display("FAIL R1 reset act=%0b%0b%0b%0b exp=0000", out_valid, taken, link_en, delay_slot);
        end
        rst = 0;
        // R2 linking group, compact
        drive(0, 0, 5, 0, 64'hffff_ffff_ffff_fffe, 26'h0_0010, PC0, 1);
        drive(0, 0, 5, 0, 64'd3, 26'h0_0010, PC0, 1);
        drive(0, 7, 7, 0, 64'd0, 26'h0_ffff, PC0, 1);
        drive(0, 7, 7, 0, MINN, 26'h0_ffff, PC0, 1);
        drive(0, 4, 9, MINN, 64'd5, 26'h0_8000, PC0, 1);
        drive(0, 4, 9, 64'd5, MINN, 26'h0_8000, PC0, 1);
        // R3 legacy fallbacks
        drive(0, 3, 0, MINN, 64'd1, 26'h0_0020, PC0, 1);
        drive(0, 3, 6, 64'd9, 64'd1, 26'h0_0020, PC0, 0);
        drive(0, 3, 6, 64'd0, 64'd1, 26'h0_fff0, PC0, 0);
        // R4 overflow group
        drive(1, 8, 4, MAXP, 64'd1, 26'h0_0004, PC0, 1);
        drive(1, 8, 4, MINN, '1, 26'h0_0004, PC0, 1);
        drive(1, 8, 4, MAXP, '1, 26'h0_0004, PC0, 1);
        drive(1, 0, 0, 64'd0, 64'd0, 26'h0_0004, PC0, 1);
        drive(1, 0, 4, 64'd7, 64'd0, 26'h0_0004, PC0, 1);
        drive(1, 2, 4, 64'd7, 64'd7, 26'h0_0004, PC0, 1);
        // R5 no-overflow group
        drive(2, 8, 8, MAXP, 64'd1, 26'h0_0004, PC0, 1);
        drive(2, 8, 4, MAXP, MINN, 26'h0_0004, PC0, 1);
        drive(2, 8, 4, 64'd0, MAXP, 26'h0_0004, PC0, 1);
        drive(2, 0, 4, 64'd7, 64'd0, 26'h0_0004, PC0, 1);
        drive(2, 2, 4, 64'd7, 64'd8, 26'h0_0004, PC0, 1);
        // R6 legacy non-branch
        drive(1, 8, 4, MAXP, 64'd1, 26'h0_0004, PC0, 0);
        drive(2, 0, 4, 64'd7, 64'd1, 26'h0_0004, PC0, 0);
        // R7, R8 zero groups and jumps
        drive(3, 1, 2, 64'd0, 64'd0, 26'h01f_fff0, PC0, 1);
        drive(3, 1, 2, 64'd3, 64'd0, 26'h01f_fff0, PC0, 1);
        drive(3, 0, 2, 64'd3, 64'h1000, 26'h0_fffc, PC0, 1);
        drive(4, 1, 2, 64'd3, 64'd0, 26'h010_0000, PC0, 1);
        drive(4, 0, 2, 64'd3, 64'h2000, 26'h0_0100, PC0, 1);
        // R9 unconditional
        drive(5, 0, 0, 0, 0, 26'h200_0000, PC0, 1);
        drive(6, 0, 0, 0, 0, 26'h000_0040, PC0, 0);
        // R11 reserved code
        drive(7, 3, 3, 0, 0, 26'h3ff_ffff, PC0, 1);
        @(negedge clk); in_valid = 0;
        @(negedge clk);
        // Random mix, with idle gaps (R1)
        for (int i = 0; i < 600; i++) begin
            logic [4:0] rsn, rtn;
            rsn = 5'($urandom_range(0, 31));
            rtn = ($urandom_range(0, 3) == 0) ? rsn : 5'($urandom_range(0, 31));
            if ($urandom_range(0, 4) == 0) rsn = 0;
            if ($urandom_range(0, 9) == 0) begin
                @(negedge clk); in_valid = 0;
            end else begin
                drive(3'($urandom_range(0, 7)), rsn, rtn, pick_val(), pick_val(),
                      26'($urandom()), {$urandom(), $urandom() & 32'hffff_fffc},
                      $urandom_range(0, 3) != 0);
            end
        end
        @(negedge clk); in_valid = 0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL R1 watchdog act=hung exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule